// File: doc/BRIEF.md
# Barrel Processor Stream Issue Scheduler

This block sits at the front of a barrel-style processor that holds many hardware thread contexts, called streams. On every clock cycle it chooses the one stream that sends its next instruction into the pipeline. Because a different stream may be chosen on each cycle, switching contexts costs nothing. The block keeps a small record for each stream: whether it is running, whether it is held, how long ago it last issued, and how many memory references it still has in flight.

A stream may issue only if all of the following hold:
- it is active;
- it is not blocked;
- a full pipeline length has passed since its previous issue;
- it has fewer than the maximum number of outstanding memory references.

Among the streams that may issue, a rotating pointer picks fairly. The search starts at the pointer and wraps around the stream range. After each grant, the pointer moves to one past the granted stream.

The memory system reports each finished reference with the ID of its stream. The instruction datapath tells the block whether the instruction granted in the current cycle is a memory reference. The grant is computed from registered per-stream state only, so the grant outputs do not depend combinationally on any input.

Top module: `mt_stream_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `issue_valid_o` is 0. Reset leaves every stream inactive, unblocked and with zero outstanding references.
- R2: A pulse on `act_i[k]` makes stream k active from the next cycle. A pulse on `deact_i[k]` makes it inactive. If both pulses arrive in the same cycle, deactivation wins. An inactive stream is never granted.
- R3: A pulse on `blk_set_i[k]` blocks stream k from the next cycle and `blk_clr_i[k]` unblocks it. If both arrive in the same cycle, the stream ends up blocked. A blocked stream is never granted.
- R4: A stream granted in cycle t is not granted again before cycle t+21 (PIPE_LEN).
- R5: The grant goes to the first eligible stream found when searching upward from the pointer, wrapping from NUM_STREAMS-1 to 0. After a grant, the pointer becomes the granted ID plus one, modulo NUM_STREAMS.
- R6: In a cycle with no eligible stream, `issue_valid_o` is 0 and the pointer keeps its value.
- R7: A stream with 8 (MAX_OUTST) outstanding references is not eligible. `mem_req_i` adds one outstanding reference to the granted stream, and only in a cycle where `issue_valid_o` is 1.
- R8: A completion (`cmp_valid_i` with `cmp_id_i`) removes one outstanding reference from that stream. A completion for a stream that has zero outstanding references has no effect. A memory issue and a completion on the same stream in the same cycle leave its count unchanged.
- R9: Whenever some stream is eligible, a grant is made. With at least 21 ready streams, a grant is made on every cycle.
- R10: Out of reset, each stream counts as having waited a full pipeline length. A stream activated in cycle t is therefore granted in cycle t+1 if it is the only one eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | NUM_STREAMS | Per-stream activate pulse |
| deact_i | input | NUM_STREAMS | Per-stream deactivate pulse |
| blk_set_i | input | NUM_STREAMS | Per-stream block pulse |
| blk_clr_i | input | NUM_STREAMS | Per-stream unblock pulse |
| mem_req_i | input | 1 | The instruction granted this cycle is a memory reference |
| cmp_valid_i | input | 1 | A memory completion arrives |
| cmp_id_i | input | log2(NUM_STREAMS) | Stream that owns the completion |
| issue_valid_o | output | 1 | A stream is granted this cycle |
| issue_id_o | output | log2(NUM_STREAMS) | Granted stream ID |

## Verification
A reference model in the bench predicts the grant on every cycle, and the stimulus drives the arbitration through several patterns:
- A lone stream shows the pipeline-length spacing and the immediate eligibility out of reset.
- Three widely spaced streams, reached after a run of idle cycles, show whether the pointer held while idle and whether the search wraps.
- A dense run of 32 streams with no memory traffic must produce a grant on every cycle, which exposes any bubble in the arbitration.
- Strided and wrapping sets of streams with memory traffic and completions about 150 to 175 cycles later push streams onto the reference limit. This separates errors in counting outstanding references from errors in the rotation.
- Directed cycles with simultaneous pulses settle which pulse takes priority, and how a memory issue and a completion on the same stream combine.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int unsigned NUM_STREAMS_DEF = 128;
  localparam int unsigned PIPE_LEN_DEF    = 21;
  localparam int unsigned MAX_OUTST_DEF   = 8;

  typedef struct packed {
    logic act;
    logic deact;
    logic blk_set;
    logic blk_clr;
  } stream_ctl_t;
endpackage

// File: rtl/mts_stream_ctx.sv
module mts_stream_ctx #(
  parameter  int unsigned PIPE_LEN  = 21,
  parameter  int unsigned MAX_OUTST = 8,
  localparam int unsigned SW        = $clog2(PIPE_LEN),
  localparam int unsigned OW        = $clog2(MAX_OUTST + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  mts_pkg::stream_ctl_t ctl_i,
  input  logic                grant_i,
  input  logic                mem_inc_i,
  input  logic                mem_dec_i,
  output logic                elig_o,
  output logic                active_o,
  output logic                blocked_o,
  output logic [OW-1:0]       outst_o
);
  localparam logic [SW-1:0] READY = SW'(PIPE_LEN - 1);
  localparam logic [OW-1:0] LIMIT = OW'(MAX_OUTST);

  logic          act_q, blk_q;
  logic [SW-1:0] since_q;
  logic [OW-1:0] outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      if (ctl_i.deact)    act_q <= 1'b0;
      else if (ctl_i.act) act_q <= 1'b1;
      if (ctl_i.blk_set)      blk_q <= 1'b1;
      else if (ctl_i.blk_clr) blk_q <= 1'b0;
    end
  end

  // cycles since last grant, saturating at READY
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= READY;
    else if (grant_i)           since_q <= '0;
    else if (since_q != READY)  since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else begin
      unique case ({mem_inc_i, mem_dec_i})
        2'b10:   outst_q <= outst_q + 1'b1;
        2'b01:   if (outst_q != '0) outst_q <= outst_q - 1'b1;
        default: outst_q <= outst_q;
      endcase
    end
  end

  assign elig_o    = act_q && !blk_q && (since_q == READY) && (outst_q < LIMIT);
  assign active_o  = act_q;
  assign blocked_o = blk_q;
  assign outst_o   = outst_q;
endmodule

// File: rtl/mts_rr_arb.sv
module mts_rr_arb #(
  parameter  int unsigned N  = 128,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;
  logic [N-1:0]  upper, pick_from;

  always_comb begin
    upper     = req_i & ({N{1'b1}} << ptr_q);
    pick_from = (|upper) ? upper : req_i;
    id_o      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pick_from[i]) id_o = IW'(i);
    end
  end

  assign valid_o = |req_i;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (valid_o) ptr_q <= (id_o == IW'(N - 1)) ? '0 : id_o + 1'b1;
  end
endmodule

// File: rtl/mt_stream_sched.sv
module mt_stream_sched #(
  parameter  int unsigned NUM_STREAMS = mts_pkg::NUM_STREAMS_DEF,
  parameter  int unsigned PIPE_LEN    = mts_pkg::PIPE_LEN_DEF,
  parameter  int unsigned MAX_OUTST   = mts_pkg::MAX_OUTST_DEF,
  localparam int unsigned IW          = $clog2(NUM_STREAMS),
  localparam int unsigned OW          = $clog2(MAX_OUTST + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_STREAMS-1:0] act_i,
  input  logic [NUM_STREAMS-1:0] deact_i,
  input  logic [NUM_STREAMS-1:0] blk_set_i,
  input  logic [NUM_STREAMS-1:0] blk_clr_i,
  input  logic                   mem_req_i,
  input  logic                   cmp_valid_i,
  input  logic [IW-1:0]          cmp_id_i,
  output logic                   issue_valid_o,
  output logic [IW-1:0]          issue_id_o
);
  logic [NUM_STREAMS-1:0]         elig, active, blocked;
  logic [NUM_STREAMS-1:0][OW-1:0] outst;
  logic [IW-1:0]                  rr_ptr;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_ctx
    mts_pkg::stream_ctl_t ctl;
    logic grant;
    assign ctl.act     = act_i[g];
    assign ctl.deact   = deact_i[g];
    assign ctl.blk_set = blk_set_i[g];
    assign ctl.blk_clr = blk_clr_i[g];
    assign grant       = issue_valid_o && (issue_id_o == IW'(g));

    mts_stream_ctx #(
      .PIPE_LEN (PIPE_LEN),
      .MAX_OUTST(MAX_OUTST)
    ) u_ctx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_i    (ctl),
      .grant_i  (grant),
      .mem_inc_i(grant && mem_req_i),
      .mem_dec_i(cmp_valid_i && (cmp_id_i == IW'(g))),
      .elig_o   (elig[g]),
      .active_o (active[g]),
      .blocked_o(blocked[g]),
      .outst_o  (outst[g])
    );
  end

  mts_rr_arb #(.N(NUM_STREAMS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .valid_o(issue_valid_o),
    .id_o   (issue_id_o),
    .ptr_o  (rr_ptr)
  );
endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
  parameter int unsigned N         = 128,
  parameter int unsigned MAX_OUTST = 8,
  parameter int unsigned IW        = 7,
  parameter int unsigned OW        = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 issue_valid_i,
  input logic [IW-1:0]        issue_id_i,
  input logic [N-1:0]         elig_i,
  input logic [N-1:0]         active_i,
  input logic [N-1:0]         blocked_i,
  input logic [N-1:0][OW-1:0] outst_i,
  input logic [IW-1:0]        ptr_i
);
  logic skipped, reached;

  // any eligible stream lying between pointer and grant in search order
  always_comb begin
    skipped = 1'b0;
    reached = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      int k;
      k = (int'(ptr_i) + i) % int'(N);
      if (k == int'(issue_id_i)) reached = 1'b1;
      else if (!reached && elig_i[k]) skipped = 1'b1;
    end
  end

  a_r2_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> active_i[issue_id_i]);
  a_r3_unblocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> !blocked_i[issue_id_i]);
  a_r4_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |=> !(issue_valid_i && issue_id_i == $past(issue_id_i)));
  a_r5_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> !skipped);
  a_r5_grant_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> elig_i[issue_id_i]);
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |=> $stable(ptr_i));
  a_r7_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> (outst_i[issue_id_i] < OW'(MAX_OUTST)));
  a_r9_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig_i) |-> issue_valid_i);
endmodule

bind mt_stream_sched mts_checker #(
  .N(NUM_STREAMS), .MAX_OUTST(MAX_OUTST), .IW(IW), .OW(OW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_o),
  .issue_id_i   (issue_id_o),
  .elig_i       (elig),
  .active_i     (active),
  .blocked_i    (blocked),
  .outst_i      (outst),
  .ptr_i        (rr_ptr)
);

// File: tb/tb_mt_stream_sched.sv
`timescale 1ns/1ps
module tb_mt_stream_sched;
  localparam int N  = 128;
  localparam int PL = 21;
  localparam int MO = 8;
  localparam int IW = 7;

  typedef struct packed {
    int base;
    int cnt;
    int stride;
    int mem;
    int cycles;
  } scen_t;

  localparam scen_t SCEN[4] = '{
    '{base: 0,   cnt: 32, stride: 1,  mem: 0, cycles: 300},
    '{base: 5,   cnt: 10, stride: 13, mem: 1, cycles: 600},
    '{base: 120, cnt: 24, stride: 1,  mem: 1, cycles: 800},
    '{base: 3,   cnt: 40, stride: 3,  mem: 1, cycles: 600}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic [N-1:0]  act, deact, bset, bclr;
  logic          mem_req, cmp_v;
  logic [IW-1:0] cmp_id;
  logic          issue_v;
  logic [IW-1:0] issue_id;

  mt_stream_sched dut (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act), .deact_i(deact),
    .blk_set_i(bset), .blk_clr_i(bclr), .mem_req_i(mem_req),
    .cmp_valid_i(cmp_v), .cmp_id_i(cmp_id),
    .issue_valid_o(issue_v), .issue_id_o(issue_id)
  );

  bit m_act[N], m_blk[N];
  int m_wait[N], m_out[N], pend_n[N];
  int pend_due[N][MO];
  int m_ptr, cyc, n_tests, n_fail, valid_cnt;
  bit auto_cmp, done;

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  function automatic bit m_elig(int k);
    return m_act[k] && !m_blk[k] && m_wait[k] == 0 && m_out[k] < MO;
  endfunction

  // one cycle: compare against model, advance model, cross the edge
  task automatic step(input string tag);
    bit v = 1'b0;
    int g = 0;
    if (auto_cmp) begin
      for (int k = 0; k < N; k++) begin
        if (!cmp_v && pend_n[k] > 0 && pend_due[k][0] <= cyc) begin
          cmp_v  = 1'b1;
          cmp_id = IW'(k);
          for (int j = 0; j < MO - 1; j++) pend_due[k][j] = pend_due[k][j+1];
          pend_n[k]--;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      int k = (m_ptr + i) % N;
      if (!v && m_elig(k)) begin v = 1'b1; g = k; end
    end
    check(tag, "issue_valid", int'(issue_v), int'(v));
    if (v) check(tag, "issue_id", int'(issue_id), g);
    if (v) valid_cnt++;
    for (int k = 0; k < N; k++) begin
      if (v && k == g) m_wait[k] = PL - 1;
      else if (m_wait[k] > 0) m_wait[k]--;
    end
    if (v) m_ptr = (g + 1) % N;
    if (v && mem_req && cmp_v && int'(cmp_id) == g) begin
      if (auto_cmp) begin pend_due[g][pend_n[g]] = cyc + 150 + (g % 24); pend_n[g]++; end
    end else begin
      if (v && mem_req) begin
        m_out[g]++;
        if (auto_cmp) begin pend_due[g][pend_n[g]] = cyc + 150 + (g % 24); pend_n[g]++; end
      end
      if (cmp_v && m_out[int'(cmp_id)] > 0) m_out[int'(cmp_id)]--;
    end
    for (int k = 0; k < N; k++) begin
      if (deact[k]) m_act[k] = 1'b0;
      else if (act[k]) m_act[k] = 1'b1;
      if (bset[k]) m_blk[k] = 1'b1;
      else if (bclr[k]) m_blk[k] = 1'b0;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    act = '0; deact = '0; bset = '0; bclr = '0; cmp_v = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    act = '0; deact = '0; bset = '0; bclr = '0;
    mem_req = 1'b0; cmp_v = 1'b0; cmp_id = '0; auto_cmp = 1'b0;
    for (int k = 0; k < N; k++) begin
      m_act[k] = 0; m_blk[k] = 0; m_wait[k] = 0; m_out[k] = 0; pend_n[k] = 0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    check("R1", "issue_valid in reset", int'(issue_v), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; done = 1'b0;
    do_reset();
    repeat (3) step("R1");

    // R10 immediate eligibility, R4 spacing
    act[5] = 1'b1;
    step("R10");
    check("R10", "issue_valid", int'(issue_v), 1);
    check("R10", "issue_id", int'(issue_id), 5);
    step("R10");
    repeat (20) begin
      check("R4", "issue_valid inside window", int'(issue_v), 0);
      step("R4");
    end
    check("R4", "reissue id", int'(issue_id), 5);
    step("R4");
    deact[5] = 1'b1;
    step("R2");

    // R6 pointer held while idle, then R5 wrap order
    repeat (12) step("R6");
    act[3] = 1'b1; act[100] = 1'b1; act[127] = 1'b1;
    step("R6");
    check("R5", "first after idle", int'(issue_id), 100);
    step("R5");
    check("R5", "second", int'(issue_id), 127);
    step("R5");
    check("R5", "wrapped", int'(issue_id), 3);
    step("R5");
    deact[3] = 1'b1; deact[100] = 1'b1; deact[127] = 1'b1;
    step("R5");

    // R2 deactivate wins, R3 block set wins
    act[7] = 1'b1; deact[7] = 1'b1;
    step("R2");
    repeat (3) step("R2");
    check("R2", "no grant after both pulses", int'(issue_v), 0);
    act[8] = 1'b1; bset[8] = 1'b1; bclr[8] = 1'b1;
    step("R3");
    repeat (3) step("R3");
    check("R3", "blocked stream", int'(issue_v), 0);
    bclr[8] = 1'b1;
    step("R3");
    check("R3", "unblocked id", int'(issue_id), 8);
    step("R3");
    deact[8] = 1'b1;
    step("R3");

    // R7 limit, R8 completions
    mem_req = 1'b1;
    act[9] = 1'b1;
    repeat (200) step("R7");
    check("R7", "stream at limit", int'(issue_v), 0);
    cmp_v = 1'b1; cmp_id = 7'd9;
    step("R8");
    check("R8", "eligible after completion", int'(issue_v), 1);
    cmp_v = 1'b1; cmp_id = 7'd9;
    step("R8");
    repeat (20) step("R8");
    check("R8", "count unchanged by issue plus completion", int'(issue_v), 1);
    step("R8");
    repeat (30) step("R8");
    check("R8", "limit reached again", int'(issue_v), 0);
    cmp_v = 1'b1; cmp_id = 7'd20;
    step("R8");
    check("R8", "completion on idle stream ignored", int'(issue_v), 0);

    // table of traffic scenarios
    do_reset();
    auto_cmp = 1'b1;
    foreach (SCEN[s]) begin
      deact = '1;
      step("R2");
      repeat (PL) step("R2");
      mem_req = SCEN[s].mem[0];
      for (int i = 0; i < SCEN[s].cnt; i++) act[(SCEN[s].base + i * SCEN[s].stride) % N] = 1'b1;
      step("R5");
      for (int c = 0; c < SCEN[s].cycles; c++) begin
        if (c == SCEN[s].cycles - 100) valid_cnt = 0;
        step(SCEN[s].mem != 0 ? "R7" : "R9");
      end
      if (SCEN[s].mem == 0 && SCEN[s].cnt >= PL)
        check("R9", "grants in last 100 cycles", valid_cnt, 100);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule